// File: doc/BRIEF.md
# GPIO Interrupt Multiplexer with Trigger Conditioning

This block takes a wide bank of GPIO pad inputs and steers a few of them onto a small set of interrupt channels. Each channel has its own pad selector, a synchronizer, an optional glitch filter and a trigger conditioner. The conditioner can sense a high or low level, a rising or falling edge, or any transition. Whatever trigger a channel is set to, its output is active-high. It is a level when the channel senses a level, and a one-cycle pulse when the channel senses an edge. The downstream interrupt controller therefore only has to handle active-high levels and rising edges.

Software sets up the channels through a small word-wide bus. The bus completes a read or a write in one cycle and has a byte enable for each of the four bytes of a word. Writing the pad selector or the mode fields of a channel starts a short quiet window on that channel. No edge is reported during that window, so retargeting a channel cannot raise a false interrupt.

Top module: `gpio_irq_mux`

## Requirements
- R1: After reset every register reads zero and every `irq_o` bit is 0. In this state each channel senses a high level on pad 0.
- R2: The mode word is at address 0x0. Bit c is the edge enable of channel c, bit 8+c is its any-transition enable and bit 16+c is its invert enable. Bits [31:24] read as zero. A write changes only the bytes whose `cfg_be` bit is set.
- R3: The pad selectors of channels 0..3 are at address 0x4 and those of channels 4..7 at address 0x8, in byte (c mod 4). The filter length of channel c is at address 0xC, bits [4c+3:4c]. Reads return what was written. Any other address reads zero and ignores writes.
- R4: With the edge, invert and any-transition bits clear, `irq_o[c]` follows the selected pad. A pad change that is set up before clock edge k shows at the output after edge k+2.
- R5: With only the invert bit set, the channel drives 1 while the pad is low, with the same latency as R4.
- R6: With only the edge bit set, a rising pad edge gives exactly one cycle of `irq_o[c]`=1, after edge k+2. A falling edge gives nothing.
- R7: With the edge and invert bits both set, only a falling pad edge gives the one-cycle pulse.
- R8: With the any-transition bit set, every pad transition gives a one-cycle pulse, whatever the edge and invert bits hold.
- R9: A nonzero filter length N holds a change back until it has been stable for 2N cycles, which adds 2N cycles of latency. A pulse shorter than 2N cycles is dropped. N=0 bypasses the filter.
- R10: A write that touches a channel's selector byte or any of mode bytes 0..2 suppresses edge and transition pulses on that channel for the next SYNC_STAGES+1 cycles. Edge history is reloaded during that window, so no spurious pulse follows it.
- R11: Activity on pads that a channel has not selected never affects that channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_i | input | NUM_PADS | Asynchronous GPIO pad inputs |
| cfg_we | input | 1 | Write strobe, sampled at the clock edge |
| cfg_addr | input | 4 | Word byte address (0x0, 0x4, 0x8, 0xC) |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| irq_o | output | NUM_CH | Active-high interrupt outputs, one per channel |

## Verification
The assertions assume that the bus drives `cfg_we` low or to a valid level on every cycle, and that a mode change reaches a channel only through a write that also starts its quiet window. The single-pulse and quiet-window properties rely on both. The stimulus meets these assumptions: it drives every bus field right after a clock edge and lowers the write strobe after one cycle. It waits past the quiet window and the synchronizer depth before it looks for a pulse. Random register writes are checked against a shadow model that merges the byte enables. Random noise on the pads that a channel has not selected probes channel isolation.

// File: rtl/gim_pkg.sv
package gim_pkg;
   localparam logic [3:0] ADR_MODE   = 4'h0;
   localparam logic [3:0] ADR_SEL_LO = 4'h4;
   localparam logic [3:0] ADR_SEL_HI = 4'h8;
   localparam logic [3:0] ADR_FILT   = 4'hC;

   typedef struct packed {
      logic edge_en;
      logic any_en;
      logic inv_en;
   } ch_mode_t;
endpackage

// File: rtl/gim_regs.sv
module gim_regs
   import gim_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int SEL_W  = 8,
   parameter int FILT_W = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [3:0]                    addr,
   input  logic [31:0]                   wdata,
   input  logic [3:0]                    be,
   output logic [31:0]                   rdata,
   output ch_mode_t [NUM_CH-1:0]         mode_o,
   output logic [NUM_CH-1:0][SEL_W-1:0]  sel_o,
   output logic [NUM_CH-1:0][FILT_W-1:0] filt_o,
   output logic [NUM_CH-1:0]             touch_o
);
   logic [NUM_CH-1:0]             edge_q, any_q, inv_q;
   logic [NUM_CH-1:0][SEL_W-1:0]  sel_q;
   logic [NUM_CH-1:0][FILT_W-1:0] filt_q;

   wire mode_hit = we && (addr == ADR_MODE);
   wire filt_hit = we && (addr == ADR_FILT);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam logic [3:0] SEL_ADR  = (c < 4) ? ADR_SEL_LO : ADR_SEL_HI;
      localparam int         SEL_BYTE = c % 4;
      localparam int         FLT_BYTE = c / 2;
      wire sel_hit = we && (addr == SEL_ADR) && be[SEL_BYTE];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            edge_q[c] <= 1'b0;
            any_q[c]  <= 1'b0;
            inv_q[c]  <= 1'b0;
            sel_q[c]  <= '0;
            filt_q[c] <= '0;
         end else begin
            if (mode_hit && be[0]) edge_q[c] <= wdata[c];
            if (mode_hit && be[1]) any_q[c]  <= wdata[8+c];
            if (mode_hit && be[2]) inv_q[c]  <= wdata[16+c];
            if (sel_hit)           sel_q[c]  <= wdata[SEL_BYTE*8 +: SEL_W];
            if (filt_hit && be[FLT_BYTE]) filt_q[c] <= wdata[c*4 +: FILT_W];
         end
      end

      assign touch_o[c] = sel_hit || (mode_hit && (|be[2:0]));
      assign mode_o[c]  = '{edge_en: edge_q[c], any_en: any_q[c], inv_en: inv_q[c]};
   end

   assign sel_o  = sel_q;
   assign filt_o = filt_q;

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         unique case (addr)
            ADR_MODE: begin
               rdata[c]    = edge_q[c];
               rdata[8+c]  = any_q[c];
               rdata[16+c] = inv_q[c];
            end
            ADR_SEL_LO: if (c < 4)  rdata[(c%4)*8 +: SEL_W] = sel_q[c];
            ADR_SEL_HI: if (c >= 4) rdata[(c%4)*8 +: SEL_W] = sel_q[c];
            ADR_FILT:   rdata[c*4 +: FILT_W] = filt_q[c];
            default: ;
         endcase
      end
   end

   // R2: a mode write without byte 1 enabled leaves the transition enables alone
   a_r2_be_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_hit && !be[1]) |=> (any_q == $past(any_q)));

   // R3: a selector write to channel 0 lands in its field
   a_r3_sel_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADR_SEL_LO && be[0]) |=> (sel_q[0] == $past(wdata[SEL_W-1:0])));
endmodule

// File: rtl/gim_channel.sv
module gim_channel
   import gim_pkg::*;
#(
   parameter int FILT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pad_bit,
   input  ch_mode_t          mode,
   input  logic [FILT_W-1:0] filt,
   input  logic              touch,
   output logic              irq
);
   localparam int              CNT_W     = FILT_W + 1;
   localparam int              HOLD_W    = $clog2(SYNC_STAGES + 2);
   localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(SYNC_STAGES + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [HOLD_W-1:0]      hold_q;
   logic                   fv_q, prev_q, irq_q;

   wire              quiet    = (hold_q != '0);
   wire              cond     = sync_q[SYNC_STAGES-1] ^ (mode.inv_en & ~mode.any_en);
   wire              bypass   = (filt == '0);
   wire              filt_out = bypass ? cond : fv_q;
   wire [CNT_W-1:0]  lim      = CNT_W'({filt, 1'b0}) - CNT_W'(1);
   wire              rise     = filt_out & ~prev_q;
   wire              change   = filt_out ^ prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         cnt_q  <= '0;
         hold_q <= '0;
         fv_q   <= 1'b0;
         prev_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pad_bit};

         if (touch)      hold_q <= HOLD_INIT;
         else if (quiet) hold_q <= hold_q - 1'b1;

         if (bypass || quiet || cond == fv_q) begin
            fv_q  <= (bypass || quiet) ? cond : fv_q;
            cnt_q <= '0;
         end else if (cnt_q == lim) begin
            fv_q  <= cond;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end

         prev_q <= quiet ? cond : filt_out;

         if (mode.any_en)       irq_q <= !quiet && change;
         else if (mode.edge_en) irq_q <= !quiet && rise;
         else                   irq_q <= filt_out;
      end
   end

   assign irq = irq_q;

   // R6: a single-edge pulse lasts exactly one cycle
   a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && mode.edge_en && !mode.any_en) |=> !irq_q);

   // R10: no edge report while the reconfiguration window is open
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && (mode.edge_en || mode.any_en)) |=> !irq_q);

   // R8: transition mode reports nothing when the conditioned input did not move
   a_r8_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (mode.any_en && !quiet && filt_out == prev_q) |=> !irq_q);
endmodule

// File: rtl/gpio_irq_mux.sv
module gpio_irq_mux
   import gim_pkg::*;
#(
   parameter int NUM_PADS    = 256,
   parameter int NUM_CH      = 8,
   parameter int FILT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PADS-1:0] pad_i,
   input  logic                cfg_we,
   input  logic [3:0]          cfg_addr,
   input  logic [31:0]         cfg_wdata,
   input  logic [3:0]          cfg_be,
   output logic [31:0]         cfg_rdata,
   output logic [NUM_CH-1:0]   irq_o
);
   localparam int SEL_W = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must be 1..8");
   end
   if (SEL_W > 8) begin : g_bad_pads
      $error("NUM_PADS must not exceed 256");
   end
   if (FILT_W < 1 || FILT_W > 4) begin : g_bad_filt
      $error("FILT_W must be 1..4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   ch_mode_t [NUM_CH-1:0]         mode;
   logic [NUM_CH-1:0][SEL_W-1:0]  sel;
   logic [NUM_CH-1:0][FILT_W-1:0] filt;
   logic [NUM_CH-1:0]             touch;

   gim_regs #(.NUM_CH(NUM_CH), .SEL_W(SEL_W), .FILT_W(FILT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .be(cfg_be), .rdata(cfg_rdata), .mode_o(mode), .sel_o(sel), .filt_o(filt),
      .touch_o(touch)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic pad_bit;
      if ((1 << SEL_W) == NUM_PADS) begin : g_full
         assign pad_bit = pad_i[sel[c]];
      end else begin : g_part
         assign pad_bit = (int'(sel[c]) < NUM_PADS) ? pad_i[sel[c]] : 1'b0;
      end

      gim_channel #(.FILT_W(FILT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk(clk), .rst_n(rst_n), .pad_bit(pad_bit), .mode(mode[c]),
         .filt(filt[c]), .touch(touch[c]), .irq(irq_o[c])
      );
   end
endmodule

// File: tb/gpio_irq_mux_test.sv
module gpio_irq_mux_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] pads = '0;
   logic         we = 1'b0;
   logic [3:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [3:0]   be = '0;
   logic [31:0]  rdata;
   logic [7:0]   irq;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;
   logic [31:0] shadow [4];

   always #10 clk = ~clk;

   gpio_irq_mux uut (
      .clk(clk), .rst_n(rst_n), .pad_i(pads), .cfg_we(we), .cfg_addr(addr),
      .cfg_wdata(wdata), .cfg_be(be), .cfg_rdata(rdata), .irq_o(irq)
   );

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                         input logic [3:0] b, input logic [31:0] keep);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{b[i]}};
      return ((old & ~m) | (d & m)) & keep;
   endfunction

   function automatic logic [31:0] reg_mask(input logic [3:0] a);
      return (a == 4'h0) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
   endfunction

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
      we = 1'b1; addr = a; wdata = d; be = b;
      if (a[1:0] == 2'b00) shadow[a[3:2]] = merge(shadow[a[3:2]], d, b, reg_mask(a));
      tick();
      we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(req, rdata, exp);
   endtask

   // pad change set before the next edge; output moves after the third edge
   task automatic expect_pulse(input string req, input int ch);
      tick(2); chk(req, 32'(irq[ch]), 32'd0);
      tick();  chk(req, 32'(irq[ch]), 32'd1);
      tick();  chk(req, 32'(irq[ch]), 32'd0);
   endtask

   task automatic expect_quiet(input string req, input int ch, input int n);
      for (int i = 0; i < n; i++) begin
         tick();
         chk(req, 32'(irq[ch]), 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 4; i++) shadow[i] = '0;
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 irq", 32'(irq), 32'd0);
      for (int a = 0; a < 16; a += 4) rd_chk("R1 reg", 4'(a), 32'd0);

      // R2/R3 random byte-masked writes against the shadow model
      for (int i = 0; i < 80; i++) begin
         logic [3:0] a;
         a = ($urandom % 5 == 0) ? 4'($urandom % 16) : 4'(($urandom % 4) * 4);
         wr(a, $urandom, 4'($urandom));
         for (int r = 0; r < 16; r += 4) begin
            if (r == 0) rd_chk("R2 mode word", 4'(r), shadow[0]);
            else        rd_chk("R3 sel/filt word", 4'(r), shadow[r/4]);
         end
         rd_chk("R3 unmapped", 4'h2, 32'd0);
      end
      for (int a = 0; a < 16; a += 4) wr(4'(a), 32'd0, 4'hF);
      pads = '0;
      tick(6);

      // R4 level high, channel 2 on pad 17
      wr(4'h4, 32'd17 << 16, 4'b0100);
      tick(5);
      pads[17] = 1'b1;
      tick(2); chk("R4 latency", 32'(irq[2]), 32'd0);
      tick();  chk("R4 level high", 32'(irq[2]), 32'd1);

      // R11 noise on other pads, pad 17 held high
      for (int i = 0; i < 40; i++) begin
         for (int w = 0; w < 8; w++) pads[w*32 +: 32] = $urandom;
         pads[17] = 1'b1;
         tick();
         chk("R11 isolation", 32'(irq[2]), 32'd1);
      end
      pads = '0; pads[17] = 1'b1;
      tick(5);
      pads[17] = 1'b0;
      tick(3); chk("R4 level drop", 32'(irq[2]), 32'd0);

      // R5 invert, channel 5 on pad 40
      wr(4'h8, 32'd40 << 8, 4'b0010);
      wr(4'h0, 32'h0020_0000, 4'b0100);
      tick(5);
      chk("R5 low level", 32'(irq[5]), 32'd1);
      pads[40] = 1'b1;
      tick(2); chk("R5 latency", 32'(irq[5]), 32'd1);
      tick();  chk("R5 high released", 32'(irq[5]), 32'd0);

      // R6 rising edge, channel 0 on pad 5
      wr(4'h4, 32'd5, 4'b0001);
      wr(4'h0, 32'h0000_0001, 4'b0001);
      tick(5);
      chk("R6 idle", 32'(irq[0]), 32'd0);
      pads[5] = 1'b1; expect_pulse("R6 rise pulse", 0);
      tick(3);
      pads[5] = 1'b0; expect_quiet("R6 fall ignored", 0, 5);

      // R7 falling edge: edge + invert
      wr(4'h0, 32'h0021_0000, 4'b0100);
      tick(5);
      pads[5] = 1'b1; expect_quiet("R7 rise ignored", 0, 5);
      pads[5] = 1'b0; expect_pulse("R7 fall pulse", 0);

      // R8 any transition, edge and invert still set
      wr(4'h0, 32'h0000_0100, 4'b0010);
      tick(5);
      chk("R8 steady low", 32'(irq[0]), 32'd0);
      pads[5] = 1'b1; expect_pulse("R8 rise pulse", 0);
      tick(3);
      chk("R8 steady high", 32'(irq[0]), 32'd0);
      pads[5] = 1'b0; expect_pulse("R8 fall pulse", 0);

      // R10 retarget onto a pad that is already high
      pads[6] = 1'b1;
      tick(3);
      wr(4'h0, 32'h0020_0000, 4'b0110);   // rising edge only on ch0, ch5 inverted
      chk("R10 after mode write", 32'(irq[0]), 32'd0);
      wr(4'h4, 32'd6, 4'b0001);
      expect_quiet("R10 no spurious edge", 0, 8);
      pads[6] = 1'b0;
      tick(4);
      pads[6] = 1'b1; expect_pulse("R10 live after window", 0);

      // R9 glitch filter, channel 1 on pad 10, N=2
      wr(4'h4, 32'd10 << 8, 4'b0010);
      wr(4'hC, 32'h0000_0020, 4'b0001);
      tick(6);
      pads[10] = 1'b1;
      tick(6); chk("R9 held back", 32'(irq[1]), 32'd0);
      tick();  chk("R9 passes after 2N", 32'(irq[1]), 32'd1);
      pads[10] = 1'b0;
      tick(6); chk("R9 release held", 32'(irq[1]), 32'd1);
      tick();  chk("R9 release passes", 32'(irq[1]), 32'd0);
      pads[10] = 1'b1;
      tick(3);
      pads[10] = 1'b0;
      expect_quiet("R9 short pulse dropped", 1, 12);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule